// File: doc/BRIEF.md
# Debug and Mass-Erase Protection Gate

This block turns a small set of stored configuration words into the enable signals that decide three things. The first is whether a debugger may reach the non-secure or the secure side of the chip. The second is whether either of two mass-erase requesters may wipe the non-volatile memory. The third is whether an early power-fail warning should stop NVM programming. The configuration words arrive as plain input buses, driven by whatever holds them in non-volatile storage. The gate copies them into shadow registers once, after reset is released, and then ignores any later change on those buses. Until that copy exists, every grant is held low.

Debug unlocking fails safe. Either debug domain opens only when its word holds the exact 32-bit unlock key 0x50FA50FA. Any other pattern keeps that domain closed, and this includes the erased all-ones pattern. Mass erase is permitted only when the erase-protection word is all ones, so a fully or partially programmed word protects. Bit 0 of the guard word arms the power-fail guard. When the guard is armed and the warning is present, NVM write requests are refused. A rising warning edge during a busy erase also produces a one-cycle abort pulse.

Top module: `prot_gate`

## Requirements
- R1: While reset is asserted, and until the shadow copy is taken (the third rising clock edge after `rst_n` rises), every grant output and `nvm_er_abort` are 0.
- R2: `dbg_grant` for a request with `dbg_secure`=0 is 1 exactly when `dbg_req`=1 and the sampled non-secure debug word equals 0x50FA50FA. Every other value, including 0xFFFFFFFF and single-bit neighbours of the key, denies.
- R3: `dbg_grant` for a request with `dbg_secure`=1 is 1 exactly when `dbg_req`=1 and the sampled secure debug word equals 0x50FA50FA. The non-secure word has no influence on this.
- R4: With the sampled erase-protection word equal to 0xFFFFFFFF, `erall_grant_ctl` follows `erall_req_ctl` and `erall_grant_ap` follows `erall_req_ap`.
- R5: With the sampled erase-protection word at any value other than 0xFFFFFFFF (0x00000000 or partially programmed), both mass-erase grants are 0.
- R6: With bit 0 of the sampled guard word at 1, `nvm_wr_grant` is 0 whenever `pof_warn`=1, and otherwise equals `nvm_wr_req`.
- R7: With the guard armed, `nvm_er_abort` is 1 for exactly the one cycle in which `pof_warn` is 1 after being 0 in the previous cycle while `nvm_er_busy`=1. A warning that stays high gives no further pulse.
- R8: With bit 0 of the sampled guard word at 0, `pof_warn` has no effect: `nvm_wr_grant` equals `nvm_wr_req` and `nvm_er_abort` stays 0.
- R9: Once sampled, the configuration words are frozen. Changing the `cfg_*` inputs afterwards does not change any grant.
- R10: No grant is asserted without its matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbg_word | input | 32 | Stored non-secure debug unlock word |
| cfg_sdbg_word | input | 32 | Stored secure debug unlock word |
| cfg_erprot_word | input | 32 | Stored mass-erase protection word |
| cfg_guard_word | input | 32 | Stored power-fail guard word (bit 0 arms) |
| dbg_req | input | 1 | Debugger access request |
| dbg_secure | input | 1 | Request targets the secure domain |
| erall_req_ctl | input | 1 | Mass-erase request from the memory controller |
| erall_req_ap | input | 1 | Mass-erase request from the debug control port |
| nvm_wr_req | input | 1 | NVM write request |
| nvm_er_busy | input | 1 | An NVM erase is in progress |
| pof_warn | input | 1 | Power-fail warning |
| dbg_grant | output | 1 | Debugger access granted |
| erall_grant_ctl | output | 1 | Controller mass erase granted |
| erall_grant_ap | output | 1 | Control-port mass erase granted |
| nvm_wr_grant | output | 1 | NVM write granted |
| nvm_er_abort | output | 1 | One-cycle abort for the running erase |

## Verification
The bench runs several configuration sets through reset. These are fully open, erased or locked, near-miss (a key off by one bit and a partially programmed erase word), and random words. Together they separate an exact-match compare from a loose or inverted one, and a strict all-ones erase test from a zero-only test. Under each set, random request, secure-attribute, busy and warning streams check every output against a bench model. Those streams cover guard-armed and guard-disarmed behaviour, and they distinguish an edge-triggered abort from a level-triggered one. Directed steps cover the deny window right after reset, warnings held across several cycles, and configuration inputs changed after sampling.

// File: rtl/prot_gate_pkg.sv
package prot_gate_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'h50FA50FA;
  localparam logic [WORD_W-1:0] ERASED_WORD = '1;
  localparam int unsigned GUARD_BIT = 0;
  localparam int unsigned N_ERASE_SRC = 2;

  typedef struct packed {
    logic [WORD_W-1:0] dbg;
    logic [WORD_W-1:0] sdbg;
    logic [WORD_W-1:0] erprot;
    logic [WORD_W-1:0] guard;
  } cfg_words_t;
endpackage

// File: rtl/pg_cfg_shadow.sv
module pg_cfg_shadow
  import prot_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_words_t cfg_in,
  output cfg_words_t cfg_q,
  output logic       cfg_valid
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rel_done;
  logic                   load_en;
  cfg_words_t             cfg_d;
  logic                   valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rel_done = sync_q[SYNC_STAGES-1];
  assign load_en  = rel_done & ~cfg_valid;

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = cfg_valid;
    if (load_en) begin
      cfg_d   = cfg_in;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{default: ERASED_WORD};
      cfg_valid <= 1'b0;
    end else if (load_en) begin
      cfg_q     <= cfg_d;
      cfg_valid <= valid_d;
    end
  end
endmodule

// File: rtl/pg_dbg_gate.sv
module pg_dbg_gate
  import prot_gate_pkg::*;
(
  input  logic              cfg_valid,
  input  logic [WORD_W-1:0] ns_word,
  input  logic [WORD_W-1:0] s_word,
  input  logic              req,
  input  logic              secure,
  output logic              grant
);
  logic [1:0][WORD_W-1:0] dom_word;
  logic [1:0]             dom_open;

  assign dom_word[0] = ns_word;
  assign dom_word[1] = s_word;

  for (genvar d = 0; d < 2; d++) begin : g_dom
    assign dom_open[d] = (dom_word[d] == UNLOCK_KEY);
  end

  assign grant = cfg_valid & req & dom_open[secure];
endmodule

// File: rtl/pg_nvm_guard.sv
module pg_nvm_guard
  import prot_gate_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_valid,
  input  logic [WORD_W-1:0]      erprot_word,
  input  logic [WORD_W-1:0]      guard_word,
  input  logic [N_ERASE_SRC-1:0] erall_req,
  input  logic                   wr_req,
  input  logic                   er_busy,
  input  logic                   warn,
  output logic [N_ERASE_SRC-1:0] erall_grant,
  output logic                   wr_grant,
  output logic                   er_abort
);
  logic erase_open;
  logic guard_on;
  logic warn_q;
  logic warn_d;
  logic warn_rise;

  assign erase_open = cfg_valid & (erprot_word == ERASED_WORD);
  assign guard_on   = guard_word[GUARD_BIT];

  for (genvar s = 0; s < N_ERASE_SRC; s++) begin : g_src
    assign erall_grant[s] = erase_open & erall_req[s];
  end

  always_comb warn_d = warn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_d;
  end

  assign warn_rise = warn & ~warn_q;
  assign wr_grant  = cfg_valid & wr_req & ~(guard_on & warn);
  assign er_abort  = cfg_valid & guard_on & er_busy & warn_rise;
endmodule

// File: rtl/prot_gate.sv
module prot_gate
  import prot_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_dbg_word,
  input  logic [31:0] cfg_sdbg_word,
  input  logic [31:0] cfg_erprot_word,
  input  logic [31:0] cfg_guard_word,
  input  logic        dbg_req,
  input  logic        dbg_secure,
  input  logic        erall_req_ctl,
  input  logic        erall_req_ap,
  input  logic        nvm_wr_req,
  input  logic        nvm_er_busy,
  input  logic        pof_warn,
  output logic        dbg_grant,
  output logic        erall_grant_ctl,
  output logic        erall_grant_ap,
  output logic        nvm_wr_grant,
  output logic        nvm_er_abort
);
  cfg_words_t             cfg_raw;
  cfg_words_t             cfg_sh;
  logic                   cfg_valid;
  logic [N_ERASE_SRC-1:0] er_req_v;
  logic [N_ERASE_SRC-1:0] er_gnt_v;

  assign cfg_raw = '{dbg: cfg_dbg_word, sdbg: cfg_sdbg_word,
                     erprot: cfg_erprot_word, guard: cfg_guard_word};

  pg_cfg_shadow #(.SYNC_STAGES(SYNC_STAGES)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_in    (cfg_raw),
    .cfg_q     (cfg_sh),
    .cfg_valid (cfg_valid)
  );

  pg_dbg_gate u_dbg (
    .cfg_valid (cfg_valid),
    .ns_word   (cfg_sh.dbg),
    .s_word    (cfg_sh.sdbg),
    .req       (dbg_req),
    .secure    (dbg_secure),
    .grant     (dbg_grant)
  );

  assign er_req_v = {erall_req_ap, erall_req_ctl};

  pg_nvm_guard u_nvm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .erprot_word (cfg_sh.erprot),
    .guard_word  (cfg_sh.guard),
    .erall_req   (er_req_v),
    .wr_req      (nvm_wr_req),
    .er_busy     (nvm_er_busy),
    .warn        (pof_warn),
    .erall_grant (er_gnt_v),
    .wr_grant    (nvm_wr_grant),
    .er_abort    (nvm_er_abort)
  );

  assign erall_grant_ctl = er_gnt_v[0];
  assign erall_grant_ap  = er_gnt_v[1];
endmodule

// File: rtl/prot_gate_chk.sv
module prot_gate_chk
  import prot_gate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input cfg_words_t cfg_sh,
  input logic       dbg_req,
  input logic       erall_req_ctl,
  input logic       erall_req_ap,
  input logic       nvm_wr_req,
  input logic       pof_warn,
  input logic       dbg_grant,
  input logic       erall_grant_ctl,
  input logic       erall_grant_ap,
  input logic       nvm_wr_grant,
  input logic       nvm_er_abort
);
  AST_DENY_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> !(dbg_grant | erall_grant_ctl | erall_grant_ap | nvm_wr_grant | nvm_er_abort)); // R1

  AST_ERASE_NEEDS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (erall_grant_ctl | erall_grant_ap) |-> (cfg_sh.erprot == ERASED_WORD)); // R5

  AST_WR_BLOCKED_ON_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sh.guard[GUARD_BIT] && pof_warn) |-> !nvm_wr_grant); // R6

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_er_abort |=> !nvm_er_abort); // R7

  AST_NO_ABORT_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sh.guard[GUARD_BIT] |-> !nvm_er_abort); // R8

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && $past(cfg_valid)) |-> $stable(cfg_sh)); // R9

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !((dbg_grant && !dbg_req) || (erall_grant_ctl && !erall_req_ctl) ||
      (erall_grant_ap && !erall_req_ap) || (nvm_wr_grant && !nvm_wr_req))); // R10
endmodule

bind prot_gate prot_gate_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_valid       (cfg_valid),
  .cfg_sh          (cfg_sh),
  .dbg_req         (dbg_req),
  .erall_req_ctl   (erall_req_ctl),
  .erall_req_ap    (erall_req_ap),
  .nvm_wr_req      (nvm_wr_req),
  .pof_warn        (pof_warn),
  .dbg_grant       (dbg_grant),
  .erall_grant_ctl (erall_grant_ctl),
  .erall_grant_ap  (erall_grant_ap),
  .nvm_wr_grant    (nvm_wr_grant),
  .nvm_er_abort    (nvm_er_abort)
);

// File: tb/prot_gate_tb.sv
module prot_gate_tb;
  localparam logic [31:0] KEY = 32'h50FA50FA;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] cfg_dbg_word, cfg_sdbg_word, cfg_erprot_word, cfg_guard_word;
  logic dbg_req, dbg_secure, erall_req_ctl, erall_req_ap;
  logic nvm_wr_req, nvm_er_busy, pof_warn;
  logic dbg_grant, erall_grant_ctl, erall_grant_ap, nvm_wr_grant, nvm_er_abort;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_dbg, m_sdbg, m_erp, m_grd;
  logic prev_warn;
  bit done = 0;

  always #10 clk = ~clk;

  prot_gate u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic f_dbg(input logic rq, input logic sec);
    return rq & ((sec ? m_sdbg : m_dbg) == KEY);
  endfunction
  function automatic logic f_er(input logic rq);
    return rq & (m_erp == 32'hFFFFFFFF);
  endfunction
  function automatic logic f_wr();
    return nvm_wr_req & ~(m_grd[0] & pof_warn);
  endfunction
  function automatic logic f_abort();
    return m_grd[0] & nvm_er_busy & pof_warn & ~prev_warn;
  endfunction

  task automatic idle_inputs();
    dbg_req = 0; dbg_secure = 0; erall_req_ctl = 0; erall_req_ap = 0;
    nvm_wr_req = 0; nvm_er_busy = 0; pof_warn = 0;
  endtask

  task automatic check_outputs();
    chk(dbg_secure ? "R3 secure debug" : "R2 debug", dbg_grant, f_dbg(dbg_req, dbg_secure));
    chk((m_erp == '1) ? "R4 erase ctl" : "R5 erase ctl", erall_grant_ctl, f_er(erall_req_ctl));
    chk((m_erp == '1) ? "R4 erase ap" : "R5 erase ap", erall_grant_ap, f_er(erall_req_ap));
    chk(m_grd[0] ? "R6 write" : "R8 write", nvm_wr_grant, f_wr());
    chk(m_grd[0] ? "R7 abort" : "R8 abort", nvm_er_abort, f_abort());
  endtask

  // drive on negedge, check mid-low-phase, then posedge registers the warning
  task automatic step(input logic rq, sec, ec, ea, wr, bz, wn);
    @(negedge clk);
    dbg_req = rq; dbg_secure = sec; erall_req_ctl = ec; erall_req_ap = ea;
    nvm_wr_req = wr; nvm_er_busy = bz; pof_warn = wn;
    #5;
    check_outputs();
    prev_warn = pof_warn;
  endtask

  task automatic do_reset(input logic [31:0] d, s, e, g);
    @(negedge clk);
    rst_n = 0;
    cfg_dbg_word = d; cfg_sdbg_word = s; cfg_erprot_word = e; cfg_guard_word = g;
    m_dbg = d; m_sdbg = s; m_erp = e; m_grd = g;
    dbg_req = 1; dbg_secure = 0; erall_req_ctl = 1; erall_req_ap = 1;
    nvm_wr_req = 1; nvm_er_busy = 0; pof_warn = 0;
    #5;
    chk("R1 deny in reset", dbg_grant | erall_grant_ctl | erall_grant_ap | nvm_wr_grant | nvm_er_abort, 1'b0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #5;
      chk("R1 deny before sample", dbg_grant | erall_grant_ctl | erall_grant_ap | nvm_wr_grant, 1'b0);
    end
    @(negedge clk);
    idle_inputs();
    prev_warn = 0;
    @(negedge clk);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [6:0] r;
      r = 7'($urandom);
      step(r[0], r[1], r[2], r[3], r[4], r[5], r[6]);
    end
  endtask

  task automatic directed_common();
    // R10: nothing requested, nothing granted
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R10 no req no grant", dbg_grant | erall_grant_ctl | erall_grant_ap | nvm_wr_grant, 1'b0);
    // R7/R8: edge while busy, then hold high
    step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1, 1, 0);
    // rising edge while not busy
    step(0, 0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1;
    idle_inputs();
    cfg_dbg_word = '1; cfg_sdbg_word = '1; cfg_erprot_word = '1; cfg_guard_word = '1;
    prev_warn = 0;

    // open set, guard armed
    do_reset(KEY, KEY, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step(1, 0, 1, 1, 1, 0, 0);
    chk("R2 key opens debug", dbg_grant, 1'b1);
    chk("R4 both erase sources open", erall_grant_ctl & erall_grant_ap, 1'b1);
    directed_common();
    // R9: change stored words after sampling, grants follow the frozen copy
    @(negedge clk);
    cfg_dbg_word = 0; cfg_sdbg_word = 0; cfg_erprot_word = 0; cfg_guard_word = 0;
    step(1, 1, 1, 1, 1, 0, 1);
    chk("R9 frozen secure debug", dbg_grant, 1'b1);
    chk("R9 frozen erase", erall_grant_ap, 1'b1);
    chk("R9 frozen guard blocks write", nvm_wr_grant, 1'b0);
    random_run(400);

    // erased / locked set, guard disarmed
    do_reset(32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hFFFFFFFE);
    step(1, 0, 1, 1, 1, 0, 1);
    chk("R2 erased word denies", dbg_grant, 1'b0);
    chk("R5 zero word blocks erase", erall_grant_ctl | erall_grant_ap, 1'b0);
    chk("R8 disarmed warn ignored", nvm_wr_grant, 1'b1);
    directed_common();
    random_run(400);

    // near misses: non-secure key off by one bit, partial erase word
    do_reset(KEY ^ 32'h1, KEY, 32'hFFFF7FFF, 32'h00000001);
    step(1, 0, 1, 1, 0, 0, 0);
    chk("R2 near-miss key denies", dbg_grant, 1'b0);
    chk("R5 partial word blocks erase", erall_grant_ctl | erall_grant_ap, 1'b0);
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R3 secure open independent", dbg_grant, 1'b1);
    directed_common();
    random_run(400);

    // secure key off by one bit, non-secure open
    do_reset(KEY, KEY ^ 32'h80000000, 32'hFFFFFFFF, 32'h00000000);
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R3 near-miss secure key denies", dbg_grant, 1'b0);
    random_run(400);

    // random words
    for (int k = 0; k < 4; k++) begin
      do_reset($urandom, $urandom, (k[0] ? 32'hFFFFFFFF : $urandom), $urandom);
      random_run(300);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule